// File: doc/BRIEF.md
# Clock Source Mode Controller

This block is a single mode register. It picks which of three oscillators drives the system clock: the slow internal oscillator, the fast internal oscillator or the external crystal input. It also holds a separate run/stop control for each oscillator and a CPU clock divider code. Software writes the register through a one-cycle write strobe. Every write is first tested against a set of legality rules. A write that breaks any rule is dropped as a whole and raises a sticky error flag.

A legal change of source does not take effect at once. The controller holds the request until the destination oscillator reports that it is stable. It then commits the new selection and gives a one-cycle done pulse. Two strap inputs restrict the graph of legal transitions. One strap keeps the slow oscillator permanently running. The other marks the external oscillator pins as unused. Wait and stop requests put the controller in a low-power state, and a wake input returns it to normal operation. Stop forces every oscillator off except a locked slow oscillator. Wait leaves the oscillators as they were.

Register layout (one byte):

- Bits 7:6 hold the divider code: 00 = /1, 01 = /2, 10 = /4, 11 = /8.
- Bits 5:4 hold the source select: 00 = slow internal, 01 = fast internal, 10 = external, 11 = reserved.
- Bit 3 always reads 0.
- Bits 2:0 are stop bits for the external, fast and slow oscillators, with bit 2 for external, bit 1 for fast and bit 0 for slow. A 1 means stopped.

Top module: `clk_mode_ctrl`

## Requirements
- R1: After reset, `mode_q` reads 8'hC6: divider /8, slow source selected, fast and external oscillators stopped. `osc_en` is 3'b001, and `busy`, `err_flag`, `switch_done`, `in_wait` and `in_stop` are all 0.
- R2: A legal write updates the divider field (bits 7:6) and the stop bits (bits 2:0) one clock after the write. While the controller is running or in wait, each `osc_en[i]` equals the inverse of stop bit i. Bit 3 always reads 0.
- R3: While `strap_lso_lock` is 1, a 1 written to bit 0 is treated as 0. The rest of the write still applies, and no error is raised.
- R4: While `strap_xin_unused` is 1, any write with source select 10 is rejected.
- R5: A write that would set the stop bit of the currently selected source is rejected.
- R6: A write that changes both the source select field and any of the effective stop bits is rejected.
- R7: A write is rejected if it selects a new source whose oscillator is stopped, or if it uses source code 11.
- R8: An accepted source change raises `busy` on the next clock and leaves `src_sel` unchanged. The controller then waits for `osc_stable` of the destination. On the clock edge that samples it high, `src_sel` takes the new value and `switch_done` pulses for exactly one cycle.
- R9: A write is rejected if it arrives while `busy` is high, while in wait or stop, or in the same cycle as a wait or stop request.
- R10: A wait request entered from the running state sets `in_wait` and leaves `osc_en` unchanged. `wake` returns the controller to running.
- R11: A stop request sets `in_stop` and drives `osc_en` to 3'b000, or to 3'b001 when `strap_lso_lock` is 1. `wake` restores the previous oscillator enables, and the register contents stay as they were.
- R12: A rejected write leaves `mode_q` unchanged and sets `err_flag`. The flag stays at 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| strap_lso_lock | input | 1 | Keeps the slow oscillator always running |
| strap_xin_unused | input | 1 | Marks the external oscillator pins as unused |
| osc_stable | input | 3 | Stable flags per oscillator (bit 0 slow, bit 1 fast, bit 2 external) |
| wait_req | input | 1 | Wait-mode request |
| stop_req | input | 1 | Stop-mode request (wins over wait) |
| wake | input | 1 | Leave wait or stop |
| osc_en | output | 3 | Oscillator run enables |
| src_sel | output | 2 | Committed clock source select |
| cpu_div | output | 2 | CPU clock divider code |
| mode_q | output | 8 | Register read value |
| busy | output | 1 | Source switch pending |
| switch_done | output | 1 | One-cycle pulse when a switch commits |
| err_flag | output | 1 | Sticky rejected-write flag |
| in_wait | output | 1 | Wait mode active |
| in_stop | output | 1 | Stop mode active |

## Verification
The bench targets the places where a wrong design would let an oscillator die under the running clock:

- A write that stops the active source. A faulty design would leave `osc_en` at zero for the selected source.
- A combined source-and-stop write. A faulty design would accept half of it.
- A switch to a stopped oscillator or to an oscillator that is not yet stable. A faulty design would move `src_sel` before `osc_stable`, or pulse `switch_done` for more than one cycle.

The bench also checks two quieter cases:

- The slow-oscillator lock must mask bit 0 silently, without raising an error, and must keep the slow oscillator running in stop.
- Writes that arrive during a pending switch or in a low-power state must be dropped. A faulty design would corrupt the register that restores the mode on wake.

// File: rtl/ckm_pkg.sv
package ckm_pkg;
  localparam int NOSC     = 3;
  localparam int SEL_W    = 2;
  localparam int DIV_W    = 2;
  localparam int REG_W    = 8;
  localparam int STOP_LSB = 0;
  localparam int RSV_BIT  = 3;
  localparam int SEL_LSB  = 4;
  localparam int DIV_LSB  = 6;

  localparam logic [SEL_W-1:0] SEL_SLOW = 2'd0;
  localparam logic [SEL_W-1:0] SEL_FAST = 2'd1;
  localparam logic [SEL_W-1:0] SEL_EXT  = 2'd2;

  localparam logic [DIV_W-1:0] DIV_RESET  = 2'd3;
  localparam logic [NOSC-1:0]  STOP_RESET = 3'b110;
  // oscillator that the lock strap may hold running
  localparam logic [NOSC-1:0]  LOCK_MASK  = 3'b001;

  typedef enum logic [1:0] {ST_RUN, ST_HOLD, ST_WAIT, ST_STOP} ckm_state_t;

  // source code i selects oscillator i; codes without an oscillator give zero
  function automatic logic [NOSC-1:0] sel_onehot(input logic [SEL_W-1:0] s);
    logic [NOSC-1:0] r;
    r = '0;
    for (int i = 0; i < NOSC; i++) begin
      if (s == SEL_W'(i)) r[i] = 1'b1;
    end
    return r;
  endfunction
endpackage

// File: rtl/ckm_rst_sync.sv
module ckm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n = sh_q[STAGES-1];
endmodule

// File: rtl/ckm_wr_check.sv
module ckm_wr_check import ckm_pkg::*; (
  input  logic             wr_en,
  input  logic             open,
  input  logic             lock_slow,
  input  logic             ext_unused,
  input  logic [SEL_W-1:0] cur_sel,
  input  logic [NOSC-1:0]  cur_stop,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [NOSC-1:0]  wr_stop,
  output logic             accept,
  output logic             reject,
  output logic             sel_change,
  output logic [NOSC-1:0]  eff_stop
);
  logic stop_change;
  logic bad_both, bad_rsv, bad_ext, bad_active, bad_dest, legal;

  always_comb begin
    eff_stop    = wr_stop & ~(lock_slow ? LOCK_MASK : '0);
    sel_change  = (wr_sel != cur_sel);
    stop_change = (eff_stop != cur_stop);
    bad_both    = sel_change && stop_change;
    bad_rsv     = (sel_onehot(wr_sel) == '0);
    bad_ext     = ext_unused && (wr_sel == SEL_EXT);
    bad_active  = |(eff_stop & sel_onehot(cur_sel));
    bad_dest    = sel_change && |(cur_stop & sel_onehot(wr_sel));
    legal       = open && !(bad_both || bad_rsv || bad_ext || bad_active || bad_dest);
    accept      = wr_en && legal;
    reject      = wr_en && !legal;
  end
endmodule

// File: rtl/ckm_seq.sv
module ckm_seq import ckm_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             sel_change,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [NOSC-1:0]  osc_stable,
  input  logic             wait_req,
  input  logic             stop_req,
  input  logic             wake,
  output ckm_state_t       state_q,
  output logic             open,
  output logic             commit,
  output logic [SEL_W-1:0] tgt_q
);
  ckm_state_t state_d;
  logic       tgt_load;

  always_comb begin
    state_d  = state_q;
    tgt_load = 1'b0;
    commit   = 1'b0;
    open     = (state_q == ST_RUN) && !wait_req && !stop_req;
    case (state_q)
      ST_RUN: begin
        if (stop_req)                  state_d = ST_STOP;
        else if (wait_req)             state_d = ST_WAIT;
        else if (accept && sel_change) begin
          state_d  = ST_HOLD;
          tgt_load = 1'b1;
        end
      end
      ST_HOLD: begin
        if (|(osc_stable & sel_onehot(tgt_q))) begin
          commit  = 1'b1;
          state_d = ST_RUN;
        end
      end
      ST_WAIT, ST_STOP: begin
        if (wake) state_d = ST_RUN;
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      tgt_q   <= SEL_SLOW;
    end else begin
      state_q <= state_d;
      if (tgt_load) tgt_q <= wr_sel;
    end
  end
endmodule

// File: rtl/ckm_osc_gate.sv
module ckm_osc_gate import ckm_pkg::*; (
  input  ckm_state_t      state,
  input  logic [NOSC-1:0] stop_bits,
  input  logic            lock_slow,
  output logic [NOSC-1:0] osc_en
);
  logic in_stop;
  assign in_stop = (state == ST_STOP);

  for (genvar i = 0; i < NOSC; i++) begin : g_osc
    if (LOCK_MASK[i]) begin : g_lockable
      assign osc_en[i] = in_stop ? lock_slow : ~stop_bits[i];
    end else begin : g_plain
      assign osc_en[i] = in_stop ? 1'b0 : ~stop_bits[i];
    end
  end
endmodule

// File: rtl/clk_mode_ctrl.sv
module clk_mode_ctrl import ckm_pkg::*; #(
  parameter int RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             strap_lso_lock,
  input  logic             strap_xin_unused,
  input  logic [NOSC-1:0]  osc_stable,
  input  logic             wait_req,
  input  logic             stop_req,
  input  logic             wake,
  output logic [NOSC-1:0]  osc_en,
  output logic [SEL_W-1:0] src_sel,
  output logic [DIV_W-1:0] cpu_div,
  output logic [REG_W-1:0] mode_q,
  output logic             busy,
  output logic             switch_done,
  output logic             err_flag,
  output logic             in_wait,
  output logic             in_stop
);
  logic             rst_core_n;
  logic [DIV_W-1:0] wr_div;
  logic [SEL_W-1:0] wr_sel;
  logic [NOSC-1:0]  wr_stop;
  logic             unused_rsv;
  logic             accept, reject, sel_change, open, commit;
  logic [NOSC-1:0]  eff_stop;
  logic [SEL_W-1:0] tgt_q;
  ckm_state_t       state;

  logic [DIV_W-1:0] div_q, div_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic [NOSC-1:0]  stop_q, stop_d;
  logic             mode_en, err_q, done_q;

  ckm_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_n(rst_core_n)
  );

  assign wr_div     = wr_data[DIV_LSB +: DIV_W];
  assign wr_sel     = wr_data[SEL_LSB +: SEL_W];
  assign wr_stop    = wr_data[STOP_LSB +: NOSC];
  assign unused_rsv = wr_data[RSV_BIT];

  ckm_wr_check u_chk (
    .wr_en(wr_en), .open(open), .lock_slow(strap_lso_lock),
    .ext_unused(strap_xin_unused), .cur_sel(sel_q), .cur_stop(stop_q),
    .wr_sel(wr_sel), .wr_stop(wr_stop), .accept(accept), .reject(reject),
    .sel_change(sel_change), .eff_stop(eff_stop)
  );

  ckm_seq u_seq (
    .clk(clk), .rst_n(rst_core_n), .accept(accept), .sel_change(sel_change),
    .wr_sel(wr_sel), .osc_stable(osc_stable), .wait_req(wait_req),
    .stop_req(stop_req), .wake(wake), .state_q(state), .open(open),
    .commit(commit), .tgt_q(tgt_q)
  );

  ckm_osc_gate u_gate (
    .state(state), .stop_bits(stop_q), .lock_slow(strap_lso_lock), .osc_en(osc_en)
  );

  always_comb begin
    div_d   = div_q;
    sel_d   = sel_q;
    stop_d  = stop_q;
    mode_en = accept || commit;
    if (accept) begin
      div_d  = wr_div;
      stop_d = eff_stop;
    end
    if (commit) sel_d = tgt_q;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      div_q  <= DIV_RESET;
      sel_q  <= SEL_SLOW;
      stop_q <= STOP_RESET;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (mode_en) begin
        div_q  <= div_d;
        sel_q  <= sel_d;
        stop_q <= stop_d;
      end
      if (reject) err_q <= 1'b1;
      done_q <= commit;
    end
  end

  assign src_sel     = sel_q;
  assign cpu_div     = div_q;
  assign mode_q      = {div_q, sel_q, 1'b0, stop_q};
  assign busy        = (state == ST_HOLD);
  assign in_wait     = (state == ST_WAIT);
  assign in_stop     = (state == ST_STOP);
  assign switch_done = done_q;
  assign err_flag    = err_q;
endmodule

// File: rtl/ckm_checker.sv
module ckm_checker import ckm_pkg::*; (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic             strap_lso_lock,
  input logic             strap_xin_unused,
  input logic             wait_req,
  input logic             stop_req,
  input logic [NOSC-1:0]  osc_en,
  input logic [SEL_W-1:0] src_sel,
  input logic [REG_W-1:0] mode_q,
  input logic             busy,
  input logic             switch_done,
  input logic             err_flag,
  input logic             in_wait,
  input logic             in_stop
);
  AST_ACTIVE_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_stop |-> |(osc_en & sel_onehot(src_sel))); // R5
  AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    src_sel != 2'b11); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    switch_done |=> !switch_done); // R8
  AST_DONE_MOVES_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    switch_done |-> src_sel != $past(src_sel)); // R8
  AST_STOP_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    in_stop |-> osc_en == {{(NOSC-1){1'b0}}, strap_lso_lock}); // R11
  AST_WAIT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    in_wait |-> osc_en == ~mode_q[NOSC-1:0]); // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag); // R12
  AST_BOTH_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !busy && !in_wait && !in_stop && !wait_req && !stop_req &&
     wr_data[5:4] != src_sel &&
     (wr_data[2:0] & ~{2'b00, strap_lso_lock}) != mode_q[2:0])
    |=> $stable(mode_q) && err_flag); // R6
  AST_EXT_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !busy && strap_xin_unused && wr_data[5:4] == 2'b10) |=> !busy); // R4
  AST_LOCK_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && strap_lso_lock && !mode_q[0]) |=> !mode_q[0]); // R3
endmodule

bind clk_mode_ctrl ckm_checker u_ckm_checker (
  .clk(clk), .rst_n(rst_core_n), .wr_en(wr_en), .wr_data(wr_data),
  .strap_lso_lock(strap_lso_lock), .strap_xin_unused(strap_xin_unused),
  .wait_req(wait_req), .stop_req(stop_req), .osc_en(osc_en),
  .src_sel(src_sel), .mode_q(mode_q), .busy(busy), .switch_done(switch_done),
  .err_flag(err_flag), .in_wait(in_wait), .in_stop(in_stop)
);

// File: tb/sim_clk_mode_ctrl.sv
module sim_clk_mode_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n, wr_en, lock, xun, wait_req, stop_req, wake;
  logic [7:0] wr_data;
  logic [2:0] osc_stable;
  logic [2:0] osc_en;
  logic [1:0] src_sel, cpu_div;
  logic [7:0] mode_q;
  logic       busy, switch_done, err_flag, in_wait, in_stop;
  int         checks = 0;
  int         errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_mode_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .strap_lso_lock(lock), .strap_xin_unused(xun), .osc_stable(osc_stable),
    .wait_req(wait_req), .stop_req(stop_req), .wake(wake), .osc_en(osc_en),
    .src_sel(src_sel), .cpu_div(cpu_div), .mode_q(mode_q), .busy(busy),
    .switch_done(switch_done), .err_flag(err_flag), .in_wait(in_wait),
    .in_stop(in_stop)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset(input logic l, input logic x);
    tick();
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; wait_req = 1'b0;
    stop_req = 1'b0; wake = 1'b0; osc_stable = 3'b001; lock = l; xun = x;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic pulse_wait();  wait_req = 1'b1; tick(); wait_req = 1'b0; endtask
  task automatic pulse_stop();  stop_req = 1'b1; tick(); stop_req = 1'b0; endtask
  task automatic pulse_wake();  wake = 1'b1;     tick(); wake = 1'b0;     endtask

  task automatic t_reset();
    do_reset(1'b0, 1'b0);
    chk("R1 mode_q", mode_q, 8'hC6);
    chk("R1 osc_en", osc_en, 3'b001);
    chk("R1 cpu_div", cpu_div, 2'd3);
    chk("R1 flags", {busy, err_flag, switch_done, in_wait, in_stop}, 5'b0);
  endtask

  task automatic t_fields();
    do_reset(1'b0, 1'b0);
    wr(8'hC4);
    chk("R2 mode after start fast", mode_q, 8'hC4);
    chk("R2 osc_en", osc_en, 3'b011);
    wr(8'h4C);
    chk("R2 div and bit3", mode_q, 8'h44);
    chk("R2 cpu_div", cpu_div, 2'd1);
    chk("R2 no error", err_flag, 1'b0);
  endtask

  task automatic t_lock();
    do_reset(1'b1, 1'b0);
    wr(8'hC5);
    chk("R3 masked bit0", mode_q, 8'hC4);
    chk("R3 no error", err_flag, 1'b0);
    chk("R3 osc_en", osc_en, 3'b011);
    pulse_stop();
    chk("R11 stop with lock", osc_en, 3'b001);
    pulse_wake();
    chk("R11 wake restores", osc_en, 3'b011);
  endtask

  task automatic t_ext_unused();
    do_reset(1'b0, 1'b1);
    osc_stable = 3'b101;
    wr(8'hC2);
    chk("R4 start ext", mode_q, 8'hC2);
    wr(8'hE2);
    chk("R4 busy", busy, 1'b0);
    chk("R4 mode kept", mode_q, 8'hC2);
    chk("R4 err", err_flag, 1'b1);
  endtask

  task automatic t_active_stop();
    do_reset(1'b0, 1'b0);
    wr(8'hC7);
    chk("R5 mode kept", mode_q, 8'hC6);
    chk("R5 err", err_flag, 1'b1);
    chk("R5 osc_en", osc_en, 3'b001);
    wr(8'hC4);
    chk("R12 later write applies", mode_q, 8'hC4);
    chk("R12 err sticky", err_flag, 1'b1);
  endtask

  task automatic t_combined();
    do_reset(1'b0, 1'b0);
    osc_stable = 3'b011;
    wr(8'hC4);
    wr(8'hD5);
    chk("R6 mode kept", mode_q, 8'hC4);
    chk("R6 no switch", busy, 1'b0);
    chk("R6 err", err_flag, 1'b1);
  endtask

  task automatic t_bad_dest();
    do_reset(1'b0, 1'b0);
    wr(8'hD6);
    chk("R7 stopped dest", mode_q, 8'hC6);
    chk("R7 no switch", busy, 1'b0);
    chk("R7 err", err_flag, 1'b1);
    do_reset(1'b0, 1'b0);
    wr(8'hF6);
    chk("R7 reserved code", mode_q, 8'hC6);
    chk("R7 reserved err", err_flag, 1'b1);
  endtask

  task automatic t_switch();
    do_reset(1'b0, 1'b0);
    wr(8'hC4);
    wr(8'hD4);
    chk("R8 busy", busy, 1'b1);
    chk("R8 sel held", src_sel, 2'd0);
    repeat (3) tick();
    chk("R8 still held", {busy, src_sel, switch_done}, {1'b1, 2'd0, 1'b0});
    wr(8'hC5);
    chk("R9 write in hold", mode_q, 8'hC4);
    chk("R9 err", err_flag, 1'b1);
    osc_stable = 3'b011;
    tick();
    chk("R8 committed", src_sel, 2'd1);
    chk("R8 done", switch_done, 1'b1);
    chk("R8 busy clear", busy, 1'b0);
    tick();
    chk("R8 done one cycle", switch_done, 1'b0);
    wr(8'hD5);
    chk("R2 stop slow", mode_q, 8'hD5);
    chk("R2 osc_en", osc_en, 3'b010);
    do_reset(1'b0, 1'b0);
    osc_stable = 3'b101;
    wr(8'hC2);
    wr(8'hE2);
    chk("R8 ext busy", busy, 1'b1);
    tick();
    chk("R8 ext commit", {src_sel, switch_done}, {2'd2, 1'b1});
  endtask

  task automatic t_lowpower();
    do_reset(1'b0, 1'b0);
    wr(8'hC4);
    pulse_wait();
    chk("R10 in_wait", in_wait, 1'b1);
    chk("R10 osc kept", osc_en, 3'b011);
    wr(8'hC6);
    chk("R9 write in wait", mode_q, 8'hC4);
    chk("R9 err", err_flag, 1'b1);
    pulse_wake();
    chk("R10 woke", {in_wait, osc_en}, {1'b0, 3'b011});
    wr_en = 1'b1; wr_data = 8'hC6; stop_req = 1'b1;
    tick();
    wr_en = 1'b0; stop_req = 1'b0;
    chk("R11 in_stop", in_stop, 1'b1);
    chk("R11 all off", osc_en, 3'b000);
    chk("R9 same-cycle write", mode_q, 8'hC4);
    pulse_wake();
    chk("R11 restored", {in_stop, osc_en, mode_q}, {1'b0, 3'b011, 8'hC4});
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_fields();
    t_lock();
    t_ext_unused();
    t_active_stop();
    t_combined();
    t_bad_dest();
    t_switch();
    t_lowpower();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule